// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block takes bytes from a host over a three-wire synchronous link: an active-low enable, a serial clock and a serial data line, plus a mode line that marks each byte as a command or as display data. All four link lines are brought into the system clock domain through two-flop synchronizers. Rising serial-clock edges are found by comparing successive synchronized samples, so the serial clock is never used as a clock.

While the enable is low, each rising serial-clock edge shifts one data bit into the current byte, most significant bit first. The eighth edge completes the byte. The block then presents the byte, together with the level the mode line had at that edge, and raises a strobe for one system clock. Bytes may follow each other with no gap while the enable stays low. Raising the enable, or asserting reset, throws away a partly received byte without producing any output for it.

The system clock must run at least four times faster than the serial clock. Each serial clock phase must also last at least two system clocks.

Top module: `serial_byte_rx`

## Requirements
- R1: Each rising serial-clock edge seen while the enable is low takes one data bit, and bits fill the byte from bit 7 down to bit 0, so the first bit sent becomes byte_out[7].
- R2: The mode-line level at the eighth rising edge of a byte sets is_data: 0 marks a command byte and 1 marks a display-data byte.
- R3: byte_valid is high for exactly one system clock per completed byte. byte_out and is_data change only in that cycle and hold their values until the next completed byte.
- R4: While the enable is high, serial-clock edges are ignored and the bit position stays at the first bit of a byte.
- R5: After a falling enable edge, the next rising serial-clock edge is taken as bit 7 of a new byte.
- R6: While the enable stays low, the rising edge that follows bit 0 is bit 7 of the next byte, so bytes can be sent back to back.
- R7: If the enable rises before the eighth bit has been taken, the partial byte is dropped: no strobe is produced and byte_out is left unchanged. The same applies when the enable rise and the eighth rising edge reach the block in the same system clock.
- R8: An active-low reset aborts the byte in progress and drives byte_out to 0, is_data to 0 and byte_valid to 0.
- R9: If the enable is low when reset is released, the next rising serial-clock edge is bit 7 of a new byte.
- R10: A serial clock that is already high when reset is released is not taken as a rising edge.
- R11: byte_valid rises on the third rising system-clock edge after the eighth serial-clock rising edge appears at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data, sampled on rising ser_clk |
| ser_en_n | input | 1 | Active-low link enable |
| ser_dc | input | 1 | Mode line: 0 = command, 1 = display data |
| byte_out | output | 8 | Last completed byte |
| is_data | output | 1 | Tag of the last completed byte |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |

## Verification
Two events can land in the same system clock: completing a byte on the eighth serial edge, and dropping it because the enable rose or reset was asserted. The bench provokes this by driving the eighth rising serial edge and the enable rise in the same system cycle. Both then pass through identical synchronizers and reach the assembler together. The expected outcome is that the drop wins: no strobe appears and byte_out keeps its previous value. This is judged both by a cycle-by-cycle reference model and by counting strobes at the port. A reset asserted in the middle of a byte is judged by the outputs going to zero at once, and by the first byte after reset release decoding correctly.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    // Bit positions of the link lines inside the synchronized pin vector
    localparam int PIN_DC   = 0;
    localparam int PIN_DIN  = 1;
    localparam int PIN_EN_N = 2;
    localparam int PIN_SCLK = 3;
    localparam int PIN_W    = 4;

    // Reset levels: serial clock high so a high pin at release is no edge,
    // enable high so the link starts idle
    localparam logic [PIN_W-1:0] PIN_RST = 4'b1100;

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
    parameter int               W       = 4,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] stab_d, stab_q;

    always_comb begin
        meta_d = async_in;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_out = stab_q;

endmodule

// File: rtl/sbr_assembler.sv
module sbr_assembler #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              en_n_s,
    input  logic              dc_s,
    output logic [BYTE_W-1:0] byte_out,
    output logic              is_data,
    output logic              byte_valid
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] obyte;
        logic              odata;
        logic              ovalid;
    } asm_state_t;

    localparam asm_state_t ST_RST = '{sclk_prev: 1'b1, cnt: '0, shreg: '0,
                                      obyte: '0, odata: 1'b0, ovalid: 1'b0};

    asm_state_t st_d, st_q;
    logic       rise;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        st_d           = st_q;
        st_d.ovalid    = 1'b0;
        st_d.sclk_prev = sclk_s;
        rise           = sclk_s & ~st_q.sclk_prev;
        shifted        = {st_q.shreg[BYTE_W-2:0], din_s};
        if (en_n_s) begin
            st_d.cnt   = '0;
            st_d.shreg = '0;
        end else if (rise) begin
            st_d.shreg = shifted;
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt    = '0;
                st_d.obyte  = shifted;
                st_d.odata  = dc_s;
                st_d.ovalid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign byte_out   = st_q.obyte;
    assign is_data    = st_q.odata;
    assign byte_valid = st_q.ovalid;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovalid |=> !st_q.ovalid); // R3

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.obyte) |-> st_q.ovalid); // R3

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |=> !st_q.ovalid); // R7

    AST_IDLE_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |=> (st_q.cnt == '0)); // R4

    AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovalid |-> ($past(st_q.cnt) == LAST_BIT)); // R1

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
    import sbr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_en_n,
    input  logic              ser_dc,
    output logic [BYTE_W-1:0] byte_out,
    output logic              is_data,
    output logic              byte_valid
);

    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_s;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCLK] = ser_clk;
        pins_raw[PIN_EN_N] = ser_en_n;
        pins_raw[PIN_DIN]  = ser_din;
        pins_raw[PIN_DC]   = ser_dc;
    end

    sbr_sync #(
        .W       (PIN_W),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    sbr_assembler #(
        .BYTE_W (BYTE_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[PIN_SCLK]),
        .din_s      (pins_s[PIN_DIN]),
        .en_n_s     (pins_s[PIN_EN_N]),
        .dc_s       (pins_s[PIN_DC]),
        .byte_out   (byte_out),
        .is_data    (is_data),
        .byte_valid (byte_valid)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (byte_out == '0 && !byte_valid && !is_data)); // R8

endmodule

// File: tb/serial_byte_rx_bench.sv
module serial_byte_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_en_n = 1'b1;
    logic       ser_dc = 1'b0;
    logic [7:0] byte_out;
    logic       is_data;
    logic       byte_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    int double_pulse = 0;
    int last_valid_cyc = -1;
    int edge_cyc = 0;
    string cur_req = "R8";

    always #5 clk = ~clk;

    serial_byte_rx u_serial_byte_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .ser_en_n   (ser_en_n),
        .ser_dc     (ser_dc),
        .byte_out   (byte_out),
        .is_data    (is_data),
        .byte_valid (byte_valid)
    );

    // Reference model: pins seen two clocks late, behavioural byte assembly
    logic [3:0] hist[$];
    logic [3:0] seen;
    logic       m_prev = 1'b1;
    int         m_n = 0;
    int         m_acc = 0;
    int         m_byte = 0;
    logic       m_data = 1'b0;
    logic       m_valid = 1'b0;
    logic       m_rise;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            hist.delete();
            m_prev = 1'b1; m_n = 0; m_acc = 0; m_byte = 0;
            m_data = 1'b0; m_valid = 1'b0;
        end else begin
            hist.push_back({ser_clk, ser_en_n, ser_din, ser_dc});
            if (hist.size() > 2) seen = hist.pop_front();
            else                 seen = 4'b1100;
            m_rise  = seen[3] && !m_prev;
            m_prev  = seen[3];
            m_valid = 1'b0;
            if (seen[2]) begin
                m_n = 0; m_acc = 0;
            end else if (m_rise) begin
                m_acc = (m_acc * 2 + int'(seen[1])) % 256;
                m_n = m_n + 1;
                if (m_n == 8) begin
                    m_byte = m_acc; m_data = seen[0]; m_valid = 1'b1;
                    m_n = 0; m_acc = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            check({byte_out, is_data, byte_valid} == 10'd0, "R8",
                  {byte_out, is_data, byte_valid}, 0);
        end else begin
            check({byte_out, is_data, byte_valid} == {m_byte[7:0], m_data, m_valid},
                  cur_req, {byte_out, is_data, byte_valid},
                  {m_byte[7:0], m_data, m_valid});
            if (byte_valid) begin
                pulses++;
                if (last_valid_cyc == cyc - 1) double_pulse++;
                last_valid_cyc = cyc;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #3; end
    endtask

    task automatic send_bit(input bit b);
        ser_din = b; ser_clk = 1'b0; tick(3);
        ser_clk = 1'b1; edge_cyc = cyc; tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit dc);
        ser_dc = dc;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    initial begin
        int p0;
        tick(4);
        check({byte_out, is_data, byte_valid} == 10'd0, "R8 reset state",
              {byte_out, is_data, byte_valid}, 0);
        rst_n = 1'b1; tick(3);

        // R1: command byte, MSB first
        cur_req = "R1"; ser_en_n = 1'b0; tick(3);
        p0 = pulses; send_byte(8'hA5, 1'b0); ser_clk = 1'b0; tick(6);
        check(byte_out == 8'hA5, "R1", byte_out, 8'hA5);
        check(is_data == 1'b0, "R2 command tag", is_data, 0);
        check(pulses - p0 == 1, "R3 one strobe", pulses - p0, 1);
        // R11: strobe three system clocks after the eighth pin edge
        check(last_valid_cyc - edge_cyc == 3, "R11 latency", last_valid_cyc - edge_cyc, 3);

        // R2: display-data byte
        cur_req = "R2"; send_byte(8'h3C, 1'b1); ser_clk = 1'b0; tick(6);
        check(byte_out == 8'h3C && is_data, "R2 data tag", {byte_out, is_data}, {8'h3C, 1'b1});

        // R6: back-to-back bytes
        cur_req = "R6"; p0 = pulses;
        send_byte(8'h81, 1'b0); send_byte(8'h7E, 1'b1); ser_clk = 1'b0; tick(6);
        ser_en_n = 1'b1; tick(4);
        check(pulses - p0 == 2, "R6 two strobes", pulses - p0, 2);
        check(byte_out == 8'h7E, "R6 second byte", byte_out, 8'h7E);

        // R7: partial byte dropped
        cur_req = "R7"; ser_en_n = 1'b0; tick(3); p0 = pulses;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        ser_en_n = 1'b1; ser_clk = 1'b0; tick(6);
        check(pulses == p0, "R7 no strobe", pulses - p0, 0);
        check(byte_out == 8'h7E, "R7 byte held", byte_out, 8'h7E);

        // R4: serial clocks while idle are ignored
        cur_req = "R4"; p0 = pulses;
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        ser_clk = 1'b0; tick(4);
        check(pulses == p0, "R4 idle no strobe", pulses - p0, 0);
        // R5: falling enable starts at bit 7
        cur_req = "R5"; ser_en_n = 1'b0; tick(3);
        send_byte(8'hC3, 1'b1); ser_clk = 1'b0; tick(6);
        check(byte_out == 8'hC3, "R5 fresh byte", byte_out, 8'hC3);

        // R7: eighth edge and enable rise in the same cycle
        cur_req = "R7"; p0 = pulses; ser_dc = 1'b0;
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        ser_clk = 1'b0; tick(3);
        ser_clk = 1'b1; ser_en_n = 1'b1; tick(6);
        ser_clk = 1'b0; tick(4);
        check(pulses == p0, "R7 coincident drop", pulses - p0, 0);
        check(byte_out == 8'hC3, "R7 coincident held", byte_out, 8'hC3);

        // R8: reset in the middle of a byte
        cur_req = "R8"; ser_en_n = 1'b0; tick(3);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        rst_n = 1'b0; tick(1);
        check({byte_out, is_data, byte_valid} == 10'd0, "R8 mid-byte reset",
              {byte_out, is_data, byte_valid}, 0);
        ser_clk = 1'b0; tick(2); rst_n = 1'b1; tick(3);
        // R9: enable low at release, next edge is bit 7
        cur_req = "R9"; p0 = pulses;
        send_byte(8'h5A, 1'b1); ser_clk = 1'b0; tick(6);
        check(byte_out == 8'h5A && pulses - p0 == 1, "R9 byte after reset", byte_out, 8'h5A);

        // R10: serial clock high across reset release
        cur_req = "R10"; ser_clk = 1'b1; rst_n = 1'b0; tick(3);
        rst_n = 1'b1; tick(8); p0 = pulses;
        send_byte(8'h96, 1'b0); ser_clk = 1'b0; tick(6);
        check(byte_out == 8'h96, "R10 no false edge", byte_out, 8'h96);
        check(pulses - p0 == 1, "R10 strobe count", pulses - p0, 1);

        check(double_pulse == 0, "R3 pulse width", double_pulse, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule